// File: doc/BRIEF.md
# Bus cycle sequencer with halt indication

This block sequences the clock states of a bus transfer. A transfer takes four visible states, T1 to T4, after one internal setup state, T0. The states are a chain of single-bit registers. A start writes a 1 into the first stage, and that 1 moves one stage per clock. Two sources can ask for a transfer: instruction prefetch and instruction execution. Another bus master can claim the bus with a hold request. The block grants a hold only between transfers, floats the bus and acknowledges the hold.

When the processor halts, the block tells the bus. It lets any transfer in progress finish and stops new prefetches. It then puts out one stand-alone T1 state, flagged with a status output. This T1 enters the chain directly, without a T0, and it never moves on into T2. A one-bit arm register allows only one such T1 for each halt. While the processor stays halted, a hold re-arms that register. When the hold ends, the halt T1 is sent again so that other bus users see that the processor is still halted. While halted with no hold, the block keeps the bus and drives it idle.

Top module: `bus_seq_halt`

## Requirements
- R1: After reset, `tstate_o` is 0 and `halt_ack_o`, `hlda_o` and `float_o` are low.
- R2: `tstate_o` is one-hot or zero. Bit 0 is T0, bit 1 is T1, bit 2 is T2, bit 3 is T3 and bit 4 is T4. A request accepted while idle shows T0, T1, T2, T3 and T4 on five consecutive cycles, starting the cycle after the request is sampled.
- R3: A request seen during T4 starts the next transfer at once, so T0 follows T4 directly. A request is never accepted during T0 to T3.
- R4: While `halt_i` is high, `pf_req_i` starts no transfer. An `ex_req_i` request is still accepted.
- R5: If `halt_i` rises while the bus is idle and no hold is active, the next cycle shows a halt T1: `tstate_o` = 5'b00010 with `halt_ack_o` high. The cycle after it shows no T2.
- R6: While `halt_i` stays high, at most one halt T1 is issued, except that a hold re-arms it (see R9).
- R7: If `halt_i` rises during a transfer, the halt T1 appears in the cycle right after that transfer's T4.
- R8: A hold request is granted only while idle or during T4. `float_o` rises on the cycle after the grant condition is sampled, and `hlda_o` rises one cycle later. No transfer starts while the hold request is present.
- R9: If a hold ends while `halt_i` is still high, `float_o` and `hlda_o` fall on the next cycle, and the cycle after that is a new halt T1.
- R10: If `halt_i` goes low for at least one cycle, a later rise of `halt_i` produces a new halt T1.
- R11: While halted without a hold, `float_o` stays low and the block keeps driving the bus.
- R12: While `hold_i` is high, no halt T1 and no T0 is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pf_req_i | input | 1 | Prefetch transfer request |
| ex_req_i | input | 1 | Execution transfer request |
| halt_i | input | 1 | Processor halted |
| hold_i | input | 1 | Another master requests the bus |
| tstate_o | output | 5 | One-hot state: bit 0 is T0, bits 1 to 4 are T1 to T4 |
| halt_ack_o | output | 1 | High during the halt T1 |
| hlda_o | output | 1 | Hold acknowledge |
| float_o | output | 1 | Bus drivers released (high impedance) |

## Verification
The block has no parameters, so the bench builds its only configuration. That configuration covers every interaction between halt and hold:
- a halt raised while idle and a halt raised in the middle of a transfer;
- execution requests made while halted;
- a hold taken while halted, followed by the re-issued halt T1 when the hold ends;
- a halt that drops and rises again.

A behavioural phase model is compared with the outputs on every clock. Directed checks are placed on the exact cycles that the requirements name.

// File: rtl/bus_seq_halt.sv
module bus_seq_halt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_req_i,
  input  logic       ex_req_i,
  input  logic       halt_i,
  input  logic       hold_i,
  output logic [4:0] tstate_o,
  output logic       halt_ack_o,
  output logic       hlda_o,
  output logic       float_o
);

  logic st0, st1, st2, st3, st4;
  logic lone;
  logic armed;
  logic granted, acked;

  logic busy_front, free, halt_nh, start, inject;

  assign busy_front = st0 | (st1 & ~lone);
  assign free       = ~busy_front & ~st2 & ~st3;
  assign halt_nh    = halt_i & ~hold_i & ~granted & ~busy_front;
  assign start      = free & ~granted & ~hold_i & (ex_req_i | (pf_req_i & ~halt_i));
  assign inject     = halt_nh & armed & free & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0 <= 1'b0; st1 <= 1'b0; st2 <= 1'b0; st3 <= 1'b0; st4 <= 1'b0;
      lone <= 1'b0;
    end else begin
      st0  <= start;
      st1  <= st0 | inject;
      lone <= inject;
      st2  <= st1 & ~lone;
      st3  <= st2;
      st4  <= st3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b1;
    else if (!halt_i || granted) armed <= 1'b1;
    else if (inject)           armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted <= 1'b0;
      acked   <= 1'b0;
    end else begin
      granted <= hold_i & (granted | free);
      acked   <= hold_i & granted;
    end
  end

  assign tstate_o   = {st4, st3, st2, st1, st0};
  assign halt_ack_o = st1 & lone;
  assign hlda_o     = acked;
  assign float_o    = granted;

endmodule

// File: rtl/bus_seq_halt_chk.sv
module bus_seq_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ex_req_i,
  input logic       halt_i,
  input logic       hold_i,
  input logic [4:0] tstate_o,
  input logic       halt_ack_o,
  input logic       hlda_o,
  input logic       float_o
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tstate_o));

  p_t0_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tstate_o[0] |=> (tstate_o[1] && !halt_ack_o));

  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate_o[1] && !halt_ack_o) |=> tstate_o[2]);

  p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tstate_o[2] |=> tstate_o[3]);

  p_t3_to_t4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tstate_o[3] |=> tstate_o[4]);

  p_pf_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !ex_req_i) |=> !tstate_o[0]);

  p_lone_t1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack_o |=> !tstate_o[2]);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack_o |=> !halt_ack_o);

  p_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(float_o) |-> (tstate_o == 5'b0));

  p_float_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    float_o |-> (tstate_o == 5'b0));

  p_hold_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!tstate_o[0] && !halt_ack_o));

  p_ack_after_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_o) |-> float_o);

endmodule

bind bus_seq_halt bus_seq_halt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ex_req_i(ex_req_i), .halt_i(halt_i),
  .hold_i(hold_i), .tstate_o(tstate_o), .halt_ack_o(halt_ack_o),
  .hlda_o(hlda_o), .float_o(float_o)
);

// File: tb/tb_bus_seq_halt.sv
module tb_bus_seq_halt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_req_i = 1'b0, ex_req_i = 1'b0, halt_i = 1'b0, hold_i = 1'b0;
  logic [4:0] tstate_o;
  logic halt_ack_o, hlda_o, float_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bus_seq_halt dut (
    .clk(clk), .rst_n(rst_n), .pf_req_i(pf_req_i), .ex_req_i(ex_req_i),
    .halt_i(halt_i), .hold_i(hold_i), .tstate_o(tstate_o),
    .halt_ack_o(halt_ack_o), .hlda_o(hlda_o), .float_o(float_o)
  );

  // behavioural model: ph 0 idle, 1..5 = T0..T4, 6 = halt T1
  int ph = 0;
  bit m_arm = 1, m_flt = 0, m_ack = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_arm = 1; m_flt = 0; m_ack = 0;
    end else begin
      bit early, fr, hn, st, fi;
      int nph;
      early = (ph == 1) || (ph == 2);
      fr = (ph == 0) || (ph == 5) || (ph == 6);
      hn = halt_i && !hold_i && !m_flt && !early;
      st = fr && !m_flt && !hold_i && (ex_req_i || (pf_req_i && !halt_i));
      fi = hn && m_arm && fr && !st;
      if (st) nph = 1;
      else if (fi) nph = 6;
      else if (ph >= 1 && ph <= 4) nph = ph + 1;
      else nph = 0;
      m_ack = m_flt && hold_i;
      m_flt = hold_i && (m_flt || fr);
      if (!halt_i || m_flt) m_arm = 1;
      else if (fi) m_arm = 0;
      ph = nph;
    end
  end

  function automatic logic [4:0] ph_vec(int p);
    if (p >= 1 && p <= 5) return 5'b1 << (p - 1);
    if (p == 6) return 5'b00010;
    return 5'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 model tstate", 32'(tstate_o), 32'(ph_vec(ph)));
      chk("R5 model halt_ack", 32'(halt_ack_o), 32'(ph == 6));
      chk("R8 model hlda", 32'(hlda_o), 32'(m_ack));
      chk("R11 model float", 32'(float_o), 32'(m_flt));
    end
    if (cyc > 4000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 tstate", 32'(tstate_o), 0);
    chk("R1 outs", 32'({halt_ack_o, hlda_o, float_o}), 0);
    rst_n = 1'b1;
    step(2);

    // R2: single prefetch cycle
    pf_req_i = 1; step(1); pf_req_i = 0;
    chk("R2 T0", 32'(tstate_o), 32'h01);
    for (int k = 1; k < 5; k++) begin
      step(1); chk("R2 chain", 32'(tstate_o), 32'(1 << k));
    end
    step(1); chk("R2 idle after T4", 32'(tstate_o), 0);

    // R3: back-to-back transfers
    ex_req_i = 1;
    for (int k = 0; k < 10; k++) begin
      step(1); chk("R3 back-to-back", 32'(tstate_o), 32'(1 << (k % 5)));
    end
    ex_req_i = 0; step(6);

    // R5: halt while idle
    halt_i = 1; step(1);
    chk("R5 halt T1", 32'(tstate_o), 32'h02);
    chk("R5 halt ack", 32'(halt_ack_o), 1);
    step(1);
    chk("R5 no T2", 32'(tstate_o), 0);
    // R6, R4, R11: steady halt with prefetch requests
    begin
      int acks = 0, act = 0, fl = 0;
      pf_req_i = 1;
      for (int k = 0; k < 20; k++) begin
        step(1);
        acks += halt_ack_o; act += (tstate_o != 0); fl += float_o;
      end
      pf_req_i = 0;
      chk("R6 no repeat", 32'(acks), 0);
      chk("R4 prefetch blocked", 32'(act), 0);
      chk("R11 still drives", 32'(fl), 0);
    end
    // R4: execution request still accepted while halted
    ex_req_i = 1; step(1); ex_req_i = 0;
    chk("R4 exec accepted", 32'(tstate_o), 32'h01);
    step(6);

    // R12, R8, R9: hold during halt
    hold_i = 1; step(1);
    chk("R8 float", 32'(float_o), 1);
    chk("R8 no ack yet", 32'(hlda_o), 0);
    step(1);
    chk("R8 hlda", 32'(hlda_o), 1);
    begin
      int acks = 0;
      for (int k = 0; k < 6; k++) begin step(1); acks += halt_ack_o; end
      chk("R12 quiet under hold", 32'(acks), 0);
    end
    hold_i = 0; step(1);
    chk("R9 release float", 32'({float_o, hlda_o}), 0);
    chk("R9 not yet", 32'(halt_ack_o), 0);
    step(1);
    chk("R9 reissued halt T1", 32'(halt_ack_o), 1);
    step(3);

    // R10: halt drop rearms
    halt_i = 0; step(2);
    halt_i = 1; step(1);
    chk("R10 fresh halt T1", 32'(halt_ack_o), 1);
    step(2);

    // R7: halt raised mid-transfer
    halt_i = 0; step(2);
    pf_req_i = 1; step(1); pf_req_i = 0;
    step(1);
    chk("R7 at T1", 32'(tstate_o), 32'h02);
    halt_i = 1;
    for (int k = 2; k < 5; k++) begin
      step(1); chk("R7 finishes", 32'(tstate_o), 32'(1 << k));
    end
    step(1);
    chk("R7 halt T1 after T4", 32'(halt_ack_o), 1);
    step(2);

    // R8: hold raised mid-transfer waits for T4
    halt_i = 0; step(2);
    pf_req_i = 1; step(1); pf_req_i = 0;
    step(1);
    hold_i = 1;
    for (int k = 2; k < 5; k++) begin
      step(1); chk("R8 transfer completes", 32'(tstate_o), 32'(1 << k));
      chk("R8 no float mid-cycle", 32'(float_o), 0);
    end
    step(1);
    chk("R8 granted after T4", 32'(float_o), 1);
    pf_req_i = 1; step(1);
    chk("R8 hlda late", 32'(hlda_o), 1);
    chk("R12 no start under hold", 32'(tstate_o), 0);
    pf_req_i = 0; hold_i = 0; step(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule